// File: doc/BRIEF.md
# Serial Command Frame Decoder

This block is the slave-side front end of a small register-oriented peripheral reached over a four-wire serial bus in clock mode 0. A frame opens when chip select falls. The first byte names the device: a fixed type nibble, two zero bits, and two bits that must equal the strap pins. The second byte carries a 4-bit opcode, a 2-bit data-register index and a 2-bit unit index. Depending on the opcode the frame then ends, exchanges one 6-bit data byte in either direction, or enters an open-ended stepping mode in which every further clock pulse nudges a setting up or down. A hold input pauses a frame mid-flight without losing its place.

The block works from a fast system clock and treats the serial clock, chip select, data-in and hold lines as inputs already synchronous to that clock. It detects serial clock edges by comparing with the previous sample. Toward the register bank it produces a one-cycle command strobe with its fields and write data, a read request whose data comes back combinationally on `rd_data`, and one-cycle step strobes with a direction bit. The serial output is presented as a data bit plus an output-enable, so the pad can be tri-stated outside.

Top module: `spi_frame_decoder`

## Requirements
- R1: After reset `so_en`, `cmd_stb`, `rd_req` and `step_stb` are 0, and no frame is accepted until `cs_n` has been seen falling from high to low; a `cs_n` held low through reset release opens no frame.
- R2: The first byte is accepted only if bits 7..4 equal 0101, bits 3..2 are 00 and bits 1..0 equal `dev_addr`; any other value drops the frame so no strobe, read request or serial output follows until the next chip select fall.
- R3: In the second byte, bits 7..4 appear on `cmd_op`, bits 3..2 on `cmd_reg` and bits 1..0 on `cmd_unit`; bits are sampled on rising serial clock edges, MSB first.
- R4: Opcodes 1101, 1110, 0001 and 1000 are two-byte commands: `cmd_stb` pulses for one cycle after `cs_n` rises, provided all 16 bits were received.
- R5: Opcodes 1010 and 1100 take a third byte whose low six bits appear on `wr_data`; `cmd_stb` pulses after `cs_n` rises, provided all 24 bits were received.
- R6: Opcodes 1001, 1011 and 0101 pulse `rd_req` once after the 16th bit and never `cmd_stb`; during the third byte `so_en` is 1 and `so_d` gives 0, 0, then `rd_data` bits 5 down to 0, each bit changing on a falling serial clock edge, and `so_en` is 0 in every other phase.
- R7: Opcode 0010 enters stepping: every rising serial clock edge after the second byte pulses `step_stb` once with `step_up` equal to the sampled data bit, for as long as chip select stays low; it never pulses `cmd_stb`.
- R8: A frame ended by `cs_n` rising before its last bit, including a rise in the same cycle as the last bit's rising clock edge, produces no `cmd_stb`.
- R9: `hold_n` low while the serial clock is low pauses the frame: clock edges are ignored, `so_en` is 0, and after `hold_n` returns high with the clock low the frame continues from the same bit.
- R10: Bits after a frame's full length, and all bits of frames with an unassigned opcode, are ignored: one command with the data of the first data byte results, or none; a new chip select fall starts from the first byte again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, idle low |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| dev_addr | input | 2 | Strap address compared with first byte bits 1..0 |
| so_d | output | 1 | Serial data out value |
| so_en | output | 1 | Serial data out enable (pad drives when 1) |
| cmd_stb | output | 1 | One-cycle command commit strobe |
| cmd_op | output | 4 | Opcode of the current frame |
| cmd_reg | output | 2 | Data-register index |
| cmd_unit | output | 2 | Unit index |
| wr_data | output | 6 | Write data of the last write frame |
| rd_req | output | 1 | One-cycle read request; `rd_data` sampled that cycle |
| rd_data | input | 6 | Read data from the register bank |
| step_stb | output | 1 | One-cycle step strobe |
| step_up | output | 1 | Step direction, 1 = up |

## Verification
Two events can meet in one system clock cycle: the rising serial clock edge that completes a frame and the chip select rise that should commit it. The bench drives both on the same edge at the end of a write frame and expects no commit, since chip select priority makes the frame short by one bit; it also pauses frames with hold and keeps pulsing the serial clock, and judges that neither the field values nor the read bit sequence shift. Near-exhaustive sweeps over every first-byte value and every opcode check the strobes against counts worked out in the bench.

// File: rtl/spi_frame_decoder.sv
module spi_frame_decoder #(
  parameter logic [3:0] DEV_TYPE = 4'b0101,
  parameter int DW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          si,
  input  logic          hold_n,
  input  logic [1:0]    dev_addr,
  output logic          so_d,
  output logic          so_en,
  output logic          cmd_stb,
  output logic [3:0]    cmd_op,
  output logic [1:0]    cmd_reg,
  output logic [1:0]    cmd_unit,
  output logic [DW-1:0] wr_data,
  output logic          rd_req,
  input  logic [DW-1:0] rd_data,
  output logic          step_stb,
  output logic          step_up
);
  localparam int BW  = 8;
  localparam int PAD = BW - DW;

  typedef enum logic [2:0] {PH_ID, PH_INS, PH_DATA, PH_STEP, PH_END, PH_DROP} phase_t;

  phase_t        phase;
  logic          cs_q, sck_q, active, held, is_rd, commit, so_q;
  logic [2:0]    bitn;
  logic [BW-1:0] sh, out_sh;
  logic [3:0]    op_q;
  logic [1:0]    reg_q, unit_q;
  logic [DW-1:0] wd_q;

  logic          cs_fall, cs_rise, live, sck_rise, sck_fall, id_ok;
  logic [BW-1:0] sh_nx;
  logic [3:0]    new_op;
  logic          op_xfer, op_wr, op_rd, op_step;

  assign cs_fall  = ~cs_n & cs_q;
  assign cs_rise  = cs_n & ~cs_q;
  assign live     = active & ~cs_n & ~held;
  assign sck_rise = live & sck & ~sck_q;
  assign sck_fall = live & ~sck & sck_q;
  assign sh_nx    = {sh[BW-2:0], si};
  assign id_ok    = (sh_nx == {DEV_TYPE, 2'b00, dev_addr});
  assign new_op   = sh_nx[7:4];
  assign op_xfer  = new_op inside {4'b1101, 4'b1110, 4'b0001, 4'b1000};
  assign op_wr    = new_op inside {4'b1010, 4'b1100};
  assign op_rd    = new_op inside {4'b1001, 4'b1011, 4'b0101};
  assign op_step  = (new_op == 4'b0010);

  assign so_d     = so_q;
  assign so_en    = live & is_rd & (phase == PH_DATA);
  assign cmd_op   = op_q;
  assign cmd_reg  = reg_q;
  assign cmd_unit = unit_q;
  assign wr_data  = wd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q     <= 1'b0;
      sck_q    <= 1'b0;
      active   <= 1'b0;
      held     <= 1'b0;
      phase    <= PH_ID;
      bitn     <= '0;
      sh       <= '0;
      out_sh   <= '0;
      so_q     <= 1'b0;
      is_rd    <= 1'b0;
      commit   <= 1'b0;
      op_q     <= '0;
      reg_q    <= '0;
      unit_q   <= '0;
      wd_q     <= '0;
      cmd_stb  <= 1'b0;
      rd_req   <= 1'b0;
      step_stb <= 1'b0;
      step_up  <= 1'b0;
    end else begin
      cs_q     <= cs_n;
      sck_q    <= sck;
      cmd_stb  <= 1'b0;
      rd_req   <= 1'b0;
      step_stb <= 1'b0;
      if (!sck) held <= ~hold_n;

      if (cs_fall) begin
        active <= 1'b1;
        phase  <= PH_ID;
        bitn   <= '0;
        commit <= 1'b0;
        is_rd  <= 1'b0;
      end else if (cs_rise) begin
        cmd_stb <= active & commit;
        active  <= 1'b0;
        phase   <= PH_ID;
        bitn    <= '0;
        commit  <= 1'b0;
        is_rd   <= 1'b0;
      end else begin
        if (rd_req) out_sh <= {{PAD{1'b0}}, rd_data};
        if (sck_rise) begin
          sh   <= sh_nx;
          bitn <= bitn + 3'd1;
          case (phase)
            PH_ID:
              if (bitn == 3'd7) phase <= id_ok ? PH_INS : PH_DROP;
            PH_INS:
              if (bitn == 3'd7) begin
                op_q   <= new_op;
                reg_q  <= sh_nx[3:2];
                unit_q <= sh_nx[1:0];
                if (op_xfer) begin
                  phase  <= PH_END;
                  commit <= 1'b1;
                end else if (op_wr) begin
                  phase <= PH_DATA;
                end else if (op_rd) begin
                  phase  <= PH_DATA;
                  is_rd  <= 1'b1;
                  rd_req <= 1'b1;
                end else if (op_step) begin
                  phase <= PH_STEP;
                end else begin
                  phase <= PH_DROP;
                end
              end
            PH_DATA:
              if (bitn == 3'd7) begin
                phase <= PH_END;
                if (!is_rd) begin
                  wd_q   <= sh_nx[DW-1:0];
                  commit <= 1'b1;
                end
              end
            PH_STEP: begin
              step_stb <= 1'b1;
              step_up  <= si;
            end
            default: ;
          endcase
        end
        if (sck_fall && is_rd && phase == PH_DATA) begin
          so_q   <= out_sh[BW-1];
          out_sh <= {out_sh[BW-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_frame_decoder_chk.sv
module spi_frame_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sck,
  input logic       hold_n,
  input logic       so_en,
  input logic       cmd_stb,
  input logic       rd_req,
  input logic       step_stb,
  input logic [3:0] cmd_op
);
  // R6
  so_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    so_en |-> !cs_n);

  // R9
  hold_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_n && !sck) |=> !so_en);

  // R4
  commit_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> $past(cs_n));

  // R4
  commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> !cmd_stb);

  // R6
  read_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (cmd_op == 4'b1001 || cmd_op == 4'b1011 || cmd_op == 4'b0101));

  // R7
  step_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_stb |-> (!cmd_stb && !rd_req && $past(!cs_n)));
endmodule

bind spi_frame_decoder spi_frame_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
  .so_en(so_en), .cmd_stb(cmd_stb), .rd_req(rd_req), .step_stb(step_stb),
  .cmd_op(cmd_op)
);

// File: tb/spi_frame_decoder_bench.sv
module spi_frame_decoder_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, cs_n, sck, si, hold_n;
  logic [1:0] dev_addr;
  logic       so_d, so_en, cmd_stb, rd_req, step_stb, step_up;
  logic [3:0] cmd_op;
  logic [1:0] cmd_reg, cmd_unit;
  logic [5:0] wr_data, rd_data;

  spi_frame_decoder u_spi_frame_decoder (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .dev_addr(dev_addr), .so_d(so_d), .so_en(so_en), .cmd_stb(cmd_stb),
    .cmd_op(cmd_op), .cmd_reg(cmd_reg), .cmd_unit(cmd_unit), .wr_data(wr_data),
    .rd_req(rd_req), .rd_data(rd_data), .step_stb(step_stb), .step_up(step_up)
  );

  function automatic logic [5:0] bank(input logic [3:0] o, input logic [1:0] r, input logic [1:0] u);
    int v;
    v = int'(o) * 7 + int'(r) * 3 + int'(u) * 5;
    return v[5:0];
  endfunction
  assign rd_data = bank(cmd_op, cmd_reg, cmd_unit);

  int n_chk = 0, n_bad = 0;
  int n_cmd = 0, n_rd = 0, n_step = 0, n_up = 0;
  logic [3:0] m_op;
  logic [1:0] m_reg, m_unit;
  logic [5:0] m_wd;
  bit done = 0;

  always @(posedge clk) if (rst_n) begin
    if (cmd_stb) begin
      n_cmd++;
      m_op <= cmd_op; m_reg <= cmd_reg; m_unit <= cmd_unit; m_wd <= wr_data;
    end
    if (rd_req) n_rd++;
    if (step_stb) begin
      n_step++;
      if (step_up) n_up++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic bit_x(input logic b, output logic so_v, output logic en_v);
    @(negedge clk); sck = 1'b0; si = b;
    repeat (3) @(negedge clk);
    so_v = so_d; en_v = so_en;
    sck = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic byte_x(input logic [7:0] b, output logic [7:0] so_b, output logic [7:0] en_b);
    logic s, e;
    for (int i = 7; i >= 0; i--) begin
      bit_x(b[i], s, e);
      so_b[i] = s; en_b[i] = e;
    end
  endtask

  task automatic cs_dn();
    @(negedge clk); sck = 1'b0;
    repeat (2) @(negedge clk);
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic cs_up();
    @(negedge clk); sck = 1'b0;
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  localparam logic [7:0] ID_OK = 8'b0101_0010;

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, e, s2, e2;
    logic sv, ev;
    int c0, r0, st0, u0;
    logic [3:0] op; logic [1:0] rg, un; logic [5:0] d;

    rst_n = 1'b0; cs_n = 1'b0; sck = 1'b0; si = 1'b0; hold_n = 1'b1; dev_addr = 2'b10;
    repeat (5) @(negedge clk);
    chk("R1 so_en in reset", so_en, 0);
    chk("R1 cmd_stb in reset", cmd_stb, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 rd_req after reset", rd_req, 0);
    chk("R1 step_stb after reset", step_stb, 0);

    // R1: cs_n low through reset: frame must not open
    byte_x(ID_OK, s, e); byte_x(8'b1101_0000, s, e);
    cs_up();
    chk("R1 no frame without cs fall", n_cmd, 0);

    // R2: sweep every first byte value
    for (int id = 0; id < 256; id++) begin
      c0 = n_cmd;
      cs_dn(); byte_x(8'(id), s, e); byte_x(8'b1101_0110, s, e); cs_up();
      chk($sformatf("R2 id %02h", id), n_cmd - c0, (id == 8'h52) ? 1 : 0);
    end
    chk("R3 op field", m_op, 4'b1101);
    chk("R3 reg field", m_reg, 2'b01);
    chk("R3 unit field", m_unit, 2'b10);
    for (int a = 0; a < 4; a++) begin
      dev_addr = 2'(a);
      c0 = n_cmd;
      cs_dn(); byte_x({6'b010100, 2'(a)}, s, e); byte_x(8'b1110_1100, s, e); cs_up();
      chk("R2 strap match", n_cmd - c0, 1);
      c0 = n_cmd;
      cs_dn(); byte_x({6'b010100, 2'(a + 1)}, s, e); byte_x(8'b1110_1100, s, e); cs_up();
      chk("R2 strap mismatch", n_cmd - c0, 0);
    end
    dev_addr = 2'b10;

    // R3..R7, R10: every opcode
    for (int o = 0; o < 16; o++) begin
      for (int k = 0; k < 4; k++) begin
        op = 4'(o); rg = 2'(k); un = 2'(3 - k); d = 6'((o * 4 + k) * 5 + 9);
        c0 = n_cmd; r0 = n_rd; st0 = n_step; u0 = n_up;
        cs_dn();
        byte_x(ID_OK, s, e);
        chk("R6 so_en off in first byte", e, 0);
        byte_x({op, rg, un}, s, e);
        chk("R6 so_en off in second byte", e, 0);
        if (op inside {4'b1101, 4'b1110, 4'b0001, 4'b1000}) begin
          cs_up();
          chk("R4 transfer commit", n_cmd - c0, 1);
          chk("R3 transfer op", m_op, op);
          chk("R3 transfer reg", m_reg, rg);
          chk("R3 transfer unit", m_unit, un);
        end else if (op == 4'b0010) begin
          for (int i = 5; i >= 0; i--) bit_x(d[i], sv, ev);
          cs_up();
          chk("R7 step count", n_step - st0, 6);
          chk("R7 step up count", n_up - u0, $countones(d));
          chk("R7 no commit", n_cmd - c0, 0);
        end else begin
          byte_x({2'b00, d}, s, e);
          cs_up();
          if (op inside {4'b1010, 4'b1100}) begin
            chk("R5 write commit", n_cmd - c0, 1);
            chk("R5 write data", m_wd, d);
            chk("R3 write op", m_op, op);
            chk("R6 so_en off in write data", e, 0);
          end else if (op inside {4'b1001, 4'b1011, 4'b0101}) begin
            chk("R6 read request", n_rd - r0, 1);
            chk("R6 read no commit", n_cmd - c0, 0);
            chk("R6 so_en in read byte", e, 8'hFF);
            chk("R6 read bits", s, {2'b00, bank(op, rg, un)});
          end else begin
            chk("R10 unassigned op no commit", n_cmd - c0, 0);
            chk("R10 unassigned op no read", n_rd - r0, 0);
            chk("R10 unassigned op so_en", e, 0);
          end
        end
        chk("R10 no stray step", (op == 4'b0010) ? 0 : n_step - st0, 0);
      end
    end

    // R8: short frames
    c0 = n_cmd;
    cs_dn(); byte_x(ID_OK, s, e);
    for (int i = 7; i >= 1; i--) bit_x(i[0], sv, ev);
    cs_up();
    chk("R8 transfer cut at 15 bits", n_cmd - c0, 0);
    c0 = n_cmd;
    cs_dn(); byte_x(ID_OK, s, e); byte_x(8'b1010_0001, s, e);
    for (int i = 7; i >= 1; i--) bit_x(1'b1, sv, ev);
    @(negedge clk); sck = 1'b0; si = 1'b1;
    repeat (3) @(negedge clk);
    sck = 1'b1; cs_n = 1'b1;
    repeat (6) @(negedge clk);
    sck = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 cs rise with last bit edge", n_cmd - c0, 0);

    // R10: extra bits after a write
    c0 = n_cmd;
    cs_dn(); byte_x(ID_OK, s, e); byte_x(8'b1100_1011, s, e);
    byte_x(8'b0010_1101, s, e); byte_x(8'hFF, s, e); cs_up();
    chk("R10 one commit with extra bits", n_cmd - c0, 1);
    chk("R10 data from first data byte", m_wd, 6'b10_1101);

    // R9: hold in read data byte
    r0 = n_rd;
    cs_dn(); byte_x(ID_OK, s, e); byte_x(8'b1011_1001, s, e);
    d = bank(4'b1011, 2'b10, 2'b01);
    s2 = {2'b00, d}; e2 = 8'h00;
    for (int i = 7; i >= 5; i--) begin
      bit_x(1'b0, sv, ev); s[i] = sv; e2[i] = ev;
    end
    @(negedge clk); sck = 1'b0;
    repeat (3) @(negedge clk); hold_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 so_en off in hold", so_en, 0);
    for (int j = 0; j < 3; j++) begin
      sck = 1'b1; si = ~si; repeat (4) @(negedge clk);
      chk("R9 so_en off in hold pulses", so_en, 0);
      sck = 1'b0; repeat (4) @(negedge clk);
    end
    hold_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 4; i >= 0; i--) begin
      bit_x(1'b0, sv, ev); s[i] = sv; e2[i] = ev;
    end
    cs_up();
    chk("R9 read bits across hold", s, s2);
    chk("R9 so_en across hold", e2, 8'hFF);
    chk("R9 one read request", n_rd - r0, 1);

    // R9: hold inside the instruction byte of a write
    c0 = n_cmd;
    cs_dn(); byte_x(ID_OK, s, e);
    for (int i = 7; i >= 4; i--) bit_x(i == 7 || i == 6, sv, ev);
    @(negedge clk); sck = 1'b0;
    repeat (3) @(negedge clk); hold_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int j = 0; j < 3; j++) begin
      sck = 1'b1; si = 1'b1; repeat (4) @(negedge clk);
      sck = 1'b0; repeat (4) @(negedge clk);
    end
    hold_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 3; i >= 0; i--) bit_x(i == 2 || i == 0, sv, ev);
    byte_x(8'b0001_0110, s, e); cs_up();
    chk("R9 write commit across hold", n_cmd - c0, 1);
    chk("R9 op across hold", m_op, 4'b1100);
    chk("R9 reg across hold", m_reg, 2'b01);
    chk("R9 unit across hold", m_unit, 2'b01);
    chk("R9 data across hold", m_wd, 6'b01_0110);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule